// File: doc/BRIEF.md
# Self-Qualifying Failover Clock Selector

This block produces one system clock from two sources that share the same nominal rate. One is a crystal-derived clock. The other is an internal RC backup oscillator. The block runs on the RC clock from reset.

The block watches the crystal input by sampling it in the RC domain. It counts crystal edges and the idle RC cycles between them. After a long enough run of closely spaced crystal edges, it hands the output over to the crystal. When the crystal goes quiet, it hands the output back to the RC clock. Both handovers use cross-synchronized enables, one chain per source. The outgoing source is gated off on its own low phase, and only then is the incoming source gated on. The output therefore stays at a steady level while the swap is in progress.

Software-facing state is kept minimal:
- a source status bit;
- a sticky change flag with a write-one strobe that clears it;
- a mask;
- a combined interrupt line.

The supply-valid input is passed on as the enable for the RC oscillator.

Top module: `clk_failover_sel`

## Requirements
- R1: After reset, the RC clock drives `clkOut`, `srcStatus` is 0, and both `irqFlag` and `irqOut` are 0.
- R2: The crystal is selected only after `QUAL_EDGES` (default 64) crystal rising edges in a row, with each edge following the previous one within `LOSS_CYCLES` (default 4) RC cycles. A shorter burst followed by silence leaves the RC clock selected.
- R3: The two sources are never both enabled onto the output. While a handover is in progress, the output holds a steady level. No high or low phase of `clkOut` is shorter than half the shorter source period.
- R4: While the crystal is selected, `LOSS_CYCLES` RC cycles with no crystal edge return the selection to the RC clock. This holds whether the crystal stopped high or stopped low.
- R5: `srcStatus` reads 0 while the RC clock is selected and 1 while the crystal is selected. The output follows the selected source once the handover completes.
- R6: `irqFlag` is set on every change of the selected source, in either direction. It then stays set until it is cleared.
- R7: A one-cycle pulse on `irqClear` clears `irqFlag`. If a source change occurs in the same RC cycle as the clear, the flag stays set.
- R8: `irqOut` is high exactly when `irqFlag` is 1 and `irqMask` is 0. The mask never changes `irqFlag`.
- R9: `rcOscEn` follows `supplyOk`.
- R10: A crystal loss discards all qualification progress. Requalifying takes a full fresh run of `QUAL_EDGES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rcClk | input | 1 | Internal RC backup clock; also clocks the monitor and the interrupt logic |
| xtalClk | input | 1 | Crystal-derived clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Backup supply is valid |
| irqMask | input | 1 | 1 blocks the interrupt output |
| irqClear | input | 1 | Write-one strobe that clears the change flag (RC domain) |
| clkOut | output | 1 | Glitch-free selected clock |
| rcOscEn | output | 1 | Enable for the RC oscillator |
| srcStatus | output | 1 | 0 = RC selected, 1 = crystal selected |
| irqFlag | output | 1 | Sticky source-change flag |
| irqOut | output | 1 | Interrupt request |

## Verification
The following properties are checked on every RC cycle:
- the two gate enables are mutually exclusive;
- the crystal enable is on only while the crystal is selected;
- a loss of crystal activity forces the selection back to RC in the next cycle;
- the selection rises only after qualification;
- the flag is set by any source change and persists until cleared.

Three behaviours only the bench scenarios can show:
- the absence of short output phases, measured in time across both handover directions and a crystal stuck high;
- the requalification after a loss and the rejection of a short burst;
- the interaction of mask, clear and a coincident source change as seen at the ports.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  // Activity summary the crystal monitor reports to the control
  typedef struct packed {
    logic gapExpired;   // no crystal edge for the loss window
    logic qualDone;     // qualification run complete
  } monEvt_t;

  // Strobes the control drives into the clock gating datapath
  typedef struct packed {
    logic selXtal;      // crystal requested as output source
    logic dropXtal;     // force the crystal enables off at once
  } selCmd_t;

endpackage

// File: rtl/clksel_xtal_monitor.sv
module clksel_xtal_monitor
  import clksel_pkg::*;
#(
  parameter int QUAL_EDGES  = 64,
  parameter int LOSS_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic    rcClk,
  input  logic    rstN,
  input  logic    xtalClk,
  output monEvt_t evt
);

  localparam int GAP_W  = $clog2(LOSS_CYCLES + 1);
  localparam int QUAL_W = $clog2(QUAL_EDGES + 1);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(LOSS_CYCLES);
  localparam logic [QUAL_W-1:0] QUAL_MAX = QUAL_W'(QUAL_EDGES);

  logic [SYNC_STAGES:0] xtalSamp;
  logic [GAP_W-1:0]     gapCnt;
  logic [QUAL_W-1:0]    goodCnt;
  logic                 xtalRise;
  logic                 gapExpired;

  // sample the crystal clock as data in the RC domain
  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) xtalSamp <= '0;
    else       xtalSamp <= {xtalSamp[SYNC_STAGES-1:0], xtalClk};
  end

  assign xtalRise   = xtalSamp[SYNC_STAGES-1] & ~xtalSamp[SYNC_STAGES];
  assign gapExpired = (gapCnt == GAP_MAX);

  // idle RC cycles since the last crystal edge, saturating
  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN)                 gapCnt <= GAP_MAX;
    else if (xtalRise)         gapCnt <= '0;
    else if (!gapExpired)      gapCnt <= gapCnt + 1'b1;
  end

  // consecutive well-spaced edges, restarted by any gap
  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
    end else if (xtalRise) begin
      if (gapExpired)               goodCnt <= QUAL_W'(1);
      else if (goodCnt != QUAL_MAX) goodCnt <= goodCnt + 1'b1;
    end else if (gapExpired) begin
      goodCnt <= '0;
    end
  end

  assign evt.gapExpired = gapExpired;
  assign evt.qualDone   = (goodCnt == QUAL_MAX);

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic    rcClk,
  input  logic    rstN,
  input  monEvt_t evt,
  input  logic    irqClear,
  input  logic    irqMask,
  output selCmd_t cmd,
  output logic    srcStatus,
  output logic    irqFlag,
  output logic    irqOut
);

  logic selXtal;
  logic selNext;
  logic srcChange;

  always_comb begin
    if (selXtal) selNext = !evt.gapExpired;
    else         selNext = evt.qualDone;
  end

  assign srcChange = (selNext != selXtal);

  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN) selXtal <= 1'b0;
    else       selXtal <= selNext;
  end

  // a change in the same cycle as a clear wins
  always_ff @(posedge rcClk or negedge rstN) begin
    if (!rstN)          irqFlag <= 1'b0;
    else if (srcChange) irqFlag <= 1'b1;
    else if (irqClear)  irqFlag <= 1'b0;
  end

  assign irqOut       = irqFlag & ~irqMask;
  assign srcStatus    = selXtal;
  assign cmd.selXtal  = selXtal;
  assign cmd.dropXtal = ~selXtal;

  AST_LOSS_FALLBACK: assert property (@(posedge rcClk) disable iff (!rstN)
    selXtal && evt.gapExpired |=> !selXtal);                         // R4
  AST_QUAL_BEFORE_SWITCH: assert property (@(posedge rcClk) disable iff (!rstN)
    $rose(selXtal) |-> $past(evt.qualDone));                        // R2
  AST_CHANGE_SETS_FLAG: assert property (@(posedge rcClk) disable iff (!rstN)
    !$stable(selXtal) |-> irqFlag);                                  // R6
  AST_FLAG_STICKY: assert property (@(posedge rcClk) disable iff (!rstN)
    $past(irqFlag) && !$past(irqClear) |-> irqFlag);                 // R6

endmodule

// File: rtl/clksel_glitchless_mux.sv
module clksel_glitchless_mux
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    rcClk,
  input  logic    xtalClk,
  input  logic    rstN,
  input  selCmd_t cmd,
  output logic    clkOut
);

  logic [SYNC_STAGES-1:0] rcEnChain;
  logic [SYNC_STAGES-1:0] xtalEnChain;
  logic                   rcEn;
  logic                   xtalEn;
  logic                   rcGo;
  logic                   xtalGo;
  logic                   xtalClr;

  assign rcEn   = rcEnChain[SYNC_STAGES-1];
  assign xtalEn = xtalEnChain[SYNC_STAGES-1];

  // each side may turn on only once the other side reports off
  assign rcGo    = ~cmd.selXtal & ~xtalEn;
  assign xtalGo  =  cmd.selXtal & ~rcEn;
  assign xtalClr = ~rstN | cmd.dropXtal;

  // enables move on the falling edge of their own clock
  always_ff @(negedge rcClk or negedge rstN) begin
    if (!rstN) rcEnChain <= '1;
    else       rcEnChain <= {rcEnChain[SYNC_STAGES-2:0], rcGo};
  end

  // a stopped crystal cannot clock its own enable low: clear it
  always_ff @(negedge xtalClk or posedge xtalClr) begin
    if (xtalClr) xtalEnChain <= '0;
    else         xtalEnChain <= {xtalEnChain[SYNC_STAGES-2:0], xtalGo};
  end

  assign clkOut = (rcClk & rcEn) | (xtalClk & xtalEn);

  AST_ONE_SOURCE: assert property (@(posedge rcClk) disable iff (!rstN)
    !(rcEn && xtalEn));                                              // R3
  AST_XTAL_ONLY_SELECTED: assert property (@(posedge rcClk) disable iff (!rstN)
    xtalEn |-> cmd.selXtal);                                         // R3

endmodule

// File: rtl/clk_failover_sel.sv
module clk_failover_sel
  import clksel_pkg::*;
#(
  parameter int QUAL_EDGES  = 64,
  parameter int LOSS_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic rcClk,
  input  logic xtalClk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic irqMask,
  input  logic irqClear,
  output logic clkOut,
  output logic rcOscEn,
  output logic srcStatus,
  output logic irqFlag,
  output logic irqOut
);

  monEvt_t monEvt;
  selCmd_t selCmd;

  clksel_xtal_monitor #(
    .QUAL_EDGES (QUAL_EDGES),
    .LOSS_CYCLES(LOSS_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_monitor (
    .rcClk  (rcClk),
    .rstN   (rstN),
    .xtalClk(xtalClk),
    .evt    (monEvt)
  );

  clksel_ctrl i_ctrl (
    .rcClk    (rcClk),
    .rstN     (rstN),
    .evt      (monEvt),
    .irqClear (irqClear),
    .irqMask  (irqMask),
    .cmd      (selCmd),
    .srcStatus(srcStatus),
    .irqFlag  (irqFlag),
    .irqOut   (irqOut)
  );

  clksel_glitchless_mux #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_mux (
    .rcClk  (rcClk),
    .xtalClk(xtalClk),
    .rstN   (rstN),
    .cmd    (selCmd),
    .clkOut (clkOut)
  );

  assign rcOscEn = supplyOk;

endmodule

// File: tb/test_clk_failover_sel.sv
`timescale 1ns/1ps
module test_clk_failover_sel;

  logic rcClk = 1'b0, xtalClk = 1'b0, xtalRun = 1'b0;
  logic rstN = 1'b0, supplyOk = 1'b1, irqMask = 1'b0, irqClear = 1'b0;
  logic clkOut, rcOscEn, srcStatus, irqFlag, irqOut;

  int total = 0;
  int bad = 0;
  int expQ[$];
  int expVal;
  logic lastStatus = 1'b0;
  realtime lastEdge = -1.0;
  realtime minPhase = 1.0e9;
  int shortCnt = 0;

  clk_failover_sel i_clk_failover_sel (
    .rcClk(rcClk), .xtalClk(xtalClk), .rstN(rstN), .supplyOk(supplyOk),
    .irqMask(irqMask), .irqClear(irqClear), .clkOut(clkOut), .rcOscEn(rcOscEn),
    .srcStatus(srcStatus), .irqFlag(irqFlag), .irqOut(irqOut)
  );

  always #2.5 rcClk = ~rcClk;              // 200 MHz
  always #6.1 if (xtalRun) xtalClk = ~xtalClk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge rcClk);
  endtask

  task automatic followsRc(input string req);
    @(posedge rcClk); #1;
    check(clkOut === 1'b1, req, clkOut, 1);
    @(negedge rcClk); #1;
    check(clkOut === 1'b0, req, clkOut, 0);
  endtask

  task automatic followsXtal(input string req);
    @(posedge xtalClk); #1;
    check(clkOut === 1'b1, req, clkOut, 1);
    @(negedge xtalClk); #1;
    check(clkOut === 1'b0, req, clkOut, 0);
  endtask

  // scoreboard monitor: every source change must match the next queued item
  always @(negedge rcClk) begin
    if (rstN && srcStatus !== lastStatus) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected source change", srcStatus, lastStatus);
      end else begin
        expVal = expQ.pop_front();
        check(srcStatus == expVal[0], "R5 source change value", srcStatus, expVal);
      end
      check(irqFlag === 1'b1, "R6 flag on change (R7 when clear held)", irqFlag, 1);
      lastStatus = srcStatus;
    end
  end

  // phase-width monitor on the output clock
  always @(posedge clkOut or negedge clkOut) begin
    if (rstN) begin
      if (lastEdge >= 0.0) begin
        if ($realtime - lastEdge < minPhase) minPhase = $realtime - lastEdge;
        if ($realtime - lastEdge < 2.4) begin
          shortCnt++;
          $display("short phase of %0.3f ns at %0t", $realtime - lastEdge, $time);
        end
      end
      lastEdge = $realtime;
    end
  end

  initial begin
    #(200000 * 5.0);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    check(srcStatus === 1'b0, "R1 status after reset", srcStatus, 0);
    check(irqFlag === 1'b0, "R1 flag after reset", irqFlag, 0);
    check(irqOut === 1'b0, "R1 irq after reset", irqOut, 0);
    followsRc("R1 output follows RC");
    // R9 supply passthrough
    check(rcOscEn === 1'b1, "R9 osc enable with supply", rcOscEn, 1);
    cyc(1);
    supplyOk = 1'b0; #1;
    check(rcOscEn === 1'b0, "R9 osc enable without supply", rcOscEn, 0);
    supplyOk = 1'b1;
    cyc(1);

    // R2 short burst (about 32 edges) then silence
    xtalRun = 1'b1;
    cyc(80);
    check(srcStatus === 1'b0, "R2 short burst not qualified", srcStatus, 0);
    xtalRun = 1'b0;
    cyc(20);
    check(srcStatus === 1'b0, "R2 still RC after burst", srcStatus, 0);
    check(irqFlag === 1'b0, "R2 no flag after burst", irqFlag, 0);

    // R10 progress discarded: about 45 fresh edges is not enough
    xtalRun = 1'b1;
    cyc(110);
    check(srcStatus === 1'b0, "R10 no carry-over of old edges", srcStatus, 0);
    expQ.push_back(1);
    cyc(120);
    check(srcStatus === 1'b1, "R5 status on crystal", srcStatus, 1);
    check(irqFlag === 1'b1, "R6 flag after switch to crystal", irqFlag, 1);
    check(irqOut === 1'b1, "R8 irq unmasked", irqOut, 1);
    followsXtal("R5 output follows crystal");

    // R7 clear pulse
    irqClear = 1'b1;
    cyc(1);
    irqClear = 1'b0;
    check(irqFlag === 1'b0, "R7 flag cleared", irqFlag, 0);
    check(irqOut === 1'b0, "R7 irq cleared", irqOut, 0);

    // R4 loss (stopped low or wherever it lands), R8 mask
    irqMask = 1'b1;
    expQ.push_back(0);
    xtalRun = 1'b0;
    cyc(20);
    check(srcStatus === 1'b0, "R4 fallback to RC", srcStatus, 0);
    check(irqFlag === 1'b1, "R8 mask leaves flag set", irqFlag, 1);
    check(irqOut === 1'b0, "R8 mask blocks irq", irqOut, 0);
    irqMask = 1'b0; #1;
    check(irqOut === 1'b1, "R8 irq after unmask", irqOut, 1);
    followsRc("R4 output back on RC");

    // R7 change coincides with held clear: set wins, then clears
    cyc(1);
    irqClear = 1'b1;
    cyc(2);
    check(irqFlag === 1'b0, "R7 held clear empties flag", irqFlag, 0);
    expQ.push_back(1);
    xtalRun = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (srcStatus === 1'b1) break;
      cyc(1);
    end
    check(srcStatus === 1'b1, "R2 requalified with clear held", srcStatus, 1);
    cyc(1);
    check(irqFlag === 1'b0, "R7 clear acts after change cycle", irqFlag, 0);
    irqClear = 1'b0;
    cyc(10);

    // R4 crystal stopped high
    @(posedge xtalClk); #1;
    xtalRun = 1'b0;
    expQ.push_back(0);
    cyc(20);
    check(xtalClk === 1'b1, "R4 crystal parked high", xtalClk, 1);
    check(srcStatus === 1'b0, "R4 fallback from stuck-high crystal", srcStatus, 0);
    followsRc("R3 output recovered after stuck-high crystal");

    cyc(5);
    check(expQ.size() == 0, "R5 all expected changes seen", expQ.size(), 0);
    check(shortCnt == 0, "R3 no output phase under half period", shortCnt, 0);
    $display("shortest output phase %0.3f ns", minPhase);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule